// File: doc/BRIEF.md
# Five-Step Skip Counter with JK Storage

This block is a three-bit synchronous counter that walks a fixed, non-binary loop of five codes instead of counting in binary. Each state bit sits in its own JK storage cell, and a small excitation network derives every J and K input from the present state. A count enable lets the loop advance on a rising clock edge; with the enable low the excitation is forced to zero, so every cell holds. A synchronous, active-high reset returns the counter to the home code.

The state is presented as `{C,B,A}`, with C the most significant bit. The loop visits five named states: HOME (000), RISE (010), PAIR (011), SKIP (101) and PEAK (110). After PEAK it goes back to HOME. The three remaining codes are stray states: STRAY1 (001), STRAY4 (100) and STRAY7 (111). Their next states were left free when the logic was minimised. They still have defined exits: STRAY1 goes to STRAY7, STRAY7 goes to HOME, and STRAY4 goes to RISE. Any corrupted value therefore rejoins the loop within two enabled edges.

The named transitions are: advance HOME→RISE, RISE→PAIR, PAIR→SKIP, SKIP→PEAK and PEAK→HOME. Recovery is STRAY1→STRAY7→HOME and STRAY4→RISE. Hold keeps any state on itself while the enable is low. Reset takes any state to HOME.

Top module: `skip_seq_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `state_o` becomes 000 after that edge, whatever `count_en` is.
- R2: With `rst` low and `count_en` high, each rising edge moves `state_o` one step along 000→010→011→101→110, and from 110 back to 000.
- R3: With `rst` low and `count_en` low, `state_o` keeps its value across the rising edge.
- R4: Each storage cell keeps its value for J=0,K=0, becomes 1 for J=1,K=0, becomes 0 for J=0,K=1, and inverts for J=1,K=1.
- R5: From the stray code 001, one enabled edge gives 111.
- R6: From the stray code 111, one enabled edge gives 000.
- R7: From the stray code 100, one enabled edge gives 010.
- R8: Starting from any loop code, `state_o` never reaches 001, 100 or 111, whatever pattern `count_en` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, to code 000 |
| count_en | input | 1 | Lets the loop advance on the edge when high |
| state_o | output | 3 | Present state, bit 2 = C, bit 1 = B, bit 0 = A |

## Verification
There is exactly one register between the inputs and `state_o`. The result of a reset, a step or a hold is therefore visible one rising edge after the inputs are sampled, and the bench reads `state_o` at the falling edge that follows that edge. Inputs change only at falling edges, and the expected value is advanced once per rising edge by a lookup function in the bench. The stray codes are placed in the cells while reset is high, and the recovery result is checked one and two edges later.

// File: rtl/skq_pkg.sv
package skq_pkg;

    localparam int STW = 3;

    typedef enum logic [STW-1:0] {
        ST_HOME   = 3'b000,
        ST_STRAY1 = 3'b001,
        ST_RISE   = 3'b010,
        ST_PAIR   = 3'b011,
        ST_STRAY4 = 3'b100,
        ST_SKIP   = 3'b101,
        ST_PEAK   = 3'b110,
        ST_STRAY7 = 3'b111
    } skq_state_t;

    function automatic logic skq_in_loop(input skq_state_t s);
        return (s == ST_HOME) || (s == ST_RISE) || (s == ST_PAIR) ||
               (s == ST_SKIP) || (s == ST_PEAK);
    endfunction

endpackage

// File: rtl/skq_jk_cell.sv
module skq_jk_cell (
    input  logic clk,
    input  logic rst,
    input  logic j_in,
    input  logic k_in,
    output logic q_out
);

    logic q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= 1'b0;
        end else begin
            unique case ({j_in, k_in})
                2'b00: q_r <= q_r;
                2'b01: q_r <= 1'b0;
                2'b10: q_r <= 1'b1;
                2'b11: q_r <= ~q_r;
            endcase
        end
    end

    always_comb q_out = q_r;

    // R4
    cell_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!j_in && !k_in) |=> $stable(q_out));
    // R4
    cell_set_chk: assert property (@(posedge clk) disable iff (rst)
        (j_in && !k_in) |=> q_out);
    // R4
    cell_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!j_in && k_in) |=> !q_out);
    // R4
    cell_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (j_in && k_in) |=> (q_out != $past(q_out)));

endmodule

// File: rtl/skq_excite.sv
module skq_excite
    import skq_pkg::*;
(
    input  skq_state_t     cur,
    input  logic           advance,
    output logic [STW-1:0] j_vec,
    output logic [STW-1:0] k_vec
);

    // Bit order of j_vec/k_vec: [2]=C, [1]=B, [0]=A.
    // Minimised drive: JC=A, KC=B|~A, JB=1, KB=A|C, JA=B&~C, KA=C.
    logic [STW-1:0] j_raw, k_raw;

    always_comb begin
        unique case (cur)
            ST_HOME:   begin j_raw = 3'b010; k_raw = 3'b100; end
            ST_RISE:   begin j_raw = 3'b011; k_raw = 3'b100; end
            ST_PAIR:   begin j_raw = 3'b111; k_raw = 3'b110; end
            ST_SKIP:   begin j_raw = 3'b110; k_raw = 3'b011; end
            ST_PEAK:   begin j_raw = 3'b010; k_raw = 3'b111; end
            ST_STRAY1: begin j_raw = 3'b110; k_raw = 3'b010; end
            ST_STRAY4: begin j_raw = 3'b010; k_raw = 3'b111; end
            ST_STRAY7: begin j_raw = 3'b110; k_raw = 3'b111; end
        endcase
    end

    always_comb begin
        j_vec = advance ? j_raw : '0;
        k_vec = advance ? k_raw : '0;
    end

endmodule

// File: rtl/skip_seq_counter.sv
module skip_seq_counter
    import skq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           count_en,
    output logic [STW-1:0] state_o
);

    logic [STW-1:0] j_vec, k_vec, q_vec;
    skq_state_t     cur;

    always_comb cur = skq_state_t'(q_vec);

    skq_excite u_excite (
        .cur     (cur),
        .advance (count_en),
        .j_vec   (j_vec),
        .k_vec   (k_vec)
    );

    // State register: one JK cell per bit.
    genvar gi;
    generate
        for (gi = 0; gi < STW; gi++) begin : g_bit
            skq_jk_cell u_ff (
                .clk   (clk),
                .rst   (rst),
                .j_in  (j_vec[gi]),
                .k_in  (k_vec[gi]),
                .q_out (q_vec[gi])
            );
        end
    endgenerate

    // Output process.
    always_comb state_o = q_vec;

    // R2
    step_home_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && cur == ST_HOME) |=> (state_o == 3'b010));
    // R2
    step_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && cur == ST_RISE) |=> (state_o == 3'b011));
    // R2
    step_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && cur == ST_PAIR) |=> (state_o == 3'b101));
    // R2
    step_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && cur == ST_SKIP) |=> (state_o == 3'b110));
    // R2
    step_peak_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && cur == ST_PEAK) |=> (state_o == 3'b000));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> $stable(state_o));
    // R5
    stray1_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && cur == ST_STRAY1) |=> (state_o == 3'b111));
    // R6
    stray7_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && cur == ST_STRAY7) |=> (state_o == 3'b000));
    // R7
    stray4_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && cur == ST_STRAY4) |=> (state_o == 3'b010));
    // R8
    loop_closed_chk: assert property (@(posedge clk) disable iff (rst)
        skq_in_loop(cur) |=> skq_in_loop(skq_state_t'(state_o)));

endmodule

// File: tb/skip_seq_counter_test.sv
`timescale 1ns/1ps
module skip_seq_counter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       count_en = 1'b0;
    logic [2:0] state_o;
    logic [2:0] exp_st = 3'b000;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    skip_seq_counter uut (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .state_o  (state_o)
    );

    function automatic logic [2:0] next_code(input logic [2:0] s);
        case (s)
            3'b000: return 3'b010;
            3'b010: return 3'b011;
            3'b011: return 3'b101;
            3'b101: return 3'b110;
            3'b110: return 3'b000;
            3'b001: return 3'b111;
            3'b111: return 3'b000;
            default: return 3'b010;
        endcase
    endfunction

    function automatic bit loop_code(input logic [2:0] s);
        return s == 3'b000 || s == 3'b010 || s == 3'b011 ||
               s == 3'b101 || s == 3'b110;
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: state_o=%b expected %b", req, got, want);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, read at the next falling edge.
    task automatic cycle(input logic r, input logic en, input string req);
        rst = r;
        count_en = en;
        @(posedge clk);
        exp_st = r ? 3'b000 : (en ? next_code(exp_st) : exp_st);
        @(negedge clk);
        check(req, state_o, exp_st);
        if (!r && loop_code(exp_st)) check("R8", {2'b00, !loop_code(state_o)}, 3'b000);
    endtask

    // Place a stray code in the cells while reset is high, then run enabled.
    task automatic plant(input logic [2:0] code, input string req);
        cycle(1'b1, 1'b1, "R1");
        force uut.g_bit[0].u_ff.q_r = code[0];
        force uut.g_bit[1].u_ff.q_r = code[1];
        force uut.g_bit[2].u_ff.q_r = code[2];
        #1;
        release uut.g_bit[0].u_ff.q_r;
        release uut.g_bit[1].u_ff.q_r;
        release uut.g_bit[2].u_ff.q_r;
        exp_st = code;
        cycle(1'b0, 1'b1, req);
        cycle(1'b0, 1'b1, req);
    endtask

    initial begin
        void'($urandom(32'd465));
        @(negedge clk);
        check("R1", state_o, 3'b000);
        cycle(1'b1, 1'b0, "R1");
        // Three full enabled loops; the cell set/clear/flip cases (R4) all occur here.
        for (int i = 0; i < 15; i++) cycle(1'b0, 1'b1, "R2 R4");
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, "R3");
        cycle(1'b0, 1'b1, "R2");
        cycle(1'b0, 1'b1, "R2");
        cycle(1'b1, 1'b1, "R1");
        plant(3'b001, "R5");
        plant(3'b111, "R6");
        plant(3'b100, "R7");
        for (int i = 0; i < 600; i++) begin
            logic r, en;
            r  = ($urandom % 40) == 0;
            en = ($urandom % 4) != 0;
            cycle(r, en, r ? "R1" : (en ? "R2" : "R3"));
        end
        cycle(1'b0, 1'b0, "R3");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #2000000;
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: state_o=%b expected run to complete", state_o);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule